// File: doc/BRIEF.md
# Parallel constant-weight symbol codec

This block packs binary words into groups of constant-weight line symbols, then unpacks them again. Each lane is N wires wide and carries a symbol with exactly M ones. At the default N=4, M=2 a lane has six legal symbols. Coding each lane on its own would carry two bits and leave two symbols unused. The codec instead treats the lanes as digits of one base-6 number, so two lanes carry 5 bits rather than 4.

The encoder takes a data word with a valid strobe and returns the lane symbols one cycle later. The decoder takes received lane symbols with a valid strobe and returns, one cycle later, the recovered word and an error flag. The flag is raised when any lane has the wrong weight, or when a legal digit pair lies beyond the last mapped word. The lane geometry (N, M and the lane count) is parameterised, and the data width follows from it.

Top module: `nck_pair_codec`

## Requirements
- R1: While rst_n is low, enc_valid, dec_valid and dec_err are 0, and enc_sym and dec_data are all zeros.
- R2: enc_valid is high exactly one cycle after in_valid was high. When in_valid was high, enc_sym holds the encoding of the in_data sampled in that cycle.
- R3: Every lane of enc_sym has exactly M ones (two at the default) whenever enc_valid is high.
- R4: Digit i selects the i-th M-weight word in ascending binary order: 0→0011, 1→0101, 2→0110, 3→1001, 4→1010, 5→1100. For value v, lane 0 (enc_sym[3:0]) carries digit v%6 and lane 1 (enc_sym[7:4]) carries digit v/6.
- R5: dec_valid is high exactly one cycle after rx_valid was high.
- R6: A legal lane pair whose value hi*6+lo is below 32 decodes to that value, with dec_err low.
- R7: If any lane of rx_sym has a weight other than M, dec_err is high and dec_data is zero.
- R8: A legal pair whose value is 32 or more (lane 1 digit 5 and lane 0 digit 2 or above) gives dec_err high and dec_data zero.
- R9: While in_valid is low, enc_sym keeps its value. While rx_valid is low, dec_data and dec_err keep theirs.
- R10: An even number of flips that turns one legal symbol into another is not flagged. The result decodes under R6 as the new symbol's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Encoder input strobe |
| in_data | input | DW (5) | Word to encode |
| enc_valid | output | 1 | Encoder output strobe |
| enc_sym | output | N*CH (8) | Lane symbols, lane k at bits [k*N +: N] |
| rx_valid | input | 1 | Decoder input strobe |
| rx_sym | input | N*CH (8) | Received lane symbols |
| dec_valid | output | 1 | Decoder output strobe |
| dec_data | output | DW (5) | Recovered word, zero on error |
| dec_err | output | 1 | Weight or range violation |

## Verification
The assertions assume that in_data never exceeds the mapped range. At the default geometry the 5-bit port enforces this by its width. They place no constraint on rx_sym, so the decoder checks must hold for any 8-bit pattern. The stimulus therefore sends every data word, every legal lane pair (including the four out-of-range ones), and every lane pair that contains at least one wrong-weight lane. Idle cycles come between these, and the inputs change during them.

// File: rtl/nck_pkg.sv
package nck_pkg;
  function automatic int binom(int n, int m);
    int r;
    r = 1;
    for (int i = 0; i < m; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic int ipow(int b, int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic int flog2(int x);
    int r;
    r = 0;
    for (int i = 1; i < 31; i++) if ((x >> i) != 0) r = i;
    return r;
  endfunction
endpackage

// File: rtl/nck_pair_codec.sv
module nck_pair_codec #(
  parameter int N  = 4,
  parameter int M  = 2,
  parameter int CH = 2,
  localparam int C  = nck_pkg::binom(N, M),
  localparam int P  = nck_pkg::ipow(C, CH),
  localparam int DW = nck_pkg::flog2(P),
  localparam int SW = N * CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          enc_valid,
  output logic [SW-1:0] enc_sym,
  input  logic          rx_valid,
  input  logic [SW-1:0] rx_sym,
  output logic          dec_valid,
  output logic [DW-1:0] dec_data,
  output logic          dec_err
);
  localparam int LIMIT = 1 << DW;

  function automatic logic [N-1:0] unrank(int idx);
    int cnt;
    logic [N-1:0] r;
    cnt = 0;
    r = '0;
    for (int w = 0; w < (1 << N); w++)
      if ($countones(w[N-1:0]) == M) begin
        if (cnt == idx) r = w[N-1:0];
        cnt++;
      end
    return r;
  endfunction

  function automatic int rank(logic [N-1:0] s);
    int cnt;
    cnt = 0;
    for (int w = 0; w < (1 << N); w++)
      if (w < int'(s) && $countones(w[N-1:0]) == M) cnt++;
    return cnt;
  endfunction

  logic [SW-1:0] sym_next;
  logic [CH-1:0] bad_w;
  int            val;
  logic          err_next;

  always_comb begin
    int t;
    t = int'(in_data);
    for (int k = 0; k < CH; k++) begin
      sym_next[k*N +: N] = unrank(t % C);
      t = t / C;
    end
  end

  always_comb begin
    val = 0;
    bad_w = '0;
    for (int k = CH - 1; k >= 0; k--) begin
      val = val * C + rank(rx_sym[k*N +: N]);
      bad_w[k] = ($countones(rx_sym[k*N +: N]) != M);
    end
  end

  assign err_next = (|bad_w) || (val >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid <= 1'b0;
      enc_sym   <= '0;
      dec_valid <= 1'b0;
      dec_data  <= '0;
      dec_err   <= 1'b0;
    end else begin
      enc_valid <= in_valid;
      dec_valid <= rx_valid;
      if (in_valid) enc_sym <= sym_next;
      if (rx_valid) begin
        dec_err  <= err_next;
        dec_data <= err_next ? '0 : DW'(val);
      end
    end
  end

  a_r2_enc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> enc_valid);
  a_r2_enc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !enc_valid);
  a_r5_dec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dec_valid);
  a_r5_dec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !dec_valid);
  a_r9_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(enc_sym));
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> dec_data == '0);

  for (genvar k = 0; k < CH; k++) begin : g_lane_chk
    a_r3_enc_weight: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> $countones(enc_sym[k*N +: N]) == M);
    a_r7_bad_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $countones(rx_sym[k*N +: N]) != M) |=> (dec_valid && dec_err));
  end
endmodule

// File: tb/nck_pair_codec_tb_top.sv
`timescale 1ns/1ps
module nck_pair_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_data = '0;
  logic       enc_valid;
  logic [7:0] enc_sym;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_sym = '0;
  logic       dec_valid;
  logic [4:0] dec_data;
  logic       dec_err;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] tab [6];

  always #10 clk = ~clk;

  nck_pair_codec dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data),
    .enc_valid(enc_valid), .enc_sym(enc_sym),
    .rx_valid(rx_valid), .rx_sym(rx_sym),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_err(dec_err)
  );

  initial begin
    int n;
    n = 0;
    for (int w = 0; w < 16; w++)
      if ($countones(w[3:0]) == 2) begin tab[n] = w[3:0]; n++; end
  end

  function automatic logic [7:0] enc_of(int v);
    return {tab[v / 6], tab[v % 6]};
  endfunction

  function automatic int idx_of(logic [3:0] s);
    for (int i = 0; i < 6; i++) if (tab[i] == s) return i;
    return -1;
  endfunction

  logic       m_ev = 0, m_dv = 0, m_err = 0;
  logic [7:0] m_sym = '0;
  logic [4:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ev <= 0; m_dv <= 0; m_err <= 0; m_sym <= '0; m_data <= '0;
    end else begin
      int lo, hi, v;
      m_ev <= in_valid;
      m_dv <= rx_valid;
      if (in_valid) m_sym <= enc_of(int'(in_data));
      if (rx_valid) begin
        lo = idx_of(rx_sym[3:0]);
        hi = idx_of(rx_sym[7:4]);
        v = hi * 6 + lo;
        if (lo < 0 || hi < 0 || v >= 32) begin
          m_err <= 1; m_data <= '0;
        end else begin
          m_err <= 0; m_data <= v[4:0];
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string etag, string dtag, logic iv, logic [4:0] id,
                      logic rv, logic [7:0] rs);
    in_valid = iv; in_data = id; rx_valid = rv; rx_sym = rs;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "enc_valid", int'(enc_valid), int'(m_ev));
    chk("R5", "dec_valid", int'(dec_valid), int'(m_dv));
    chk(etag, "enc_sym", int'(enc_sym), int'(m_sym));
    if (enc_valid) chk("R3", "lane weights", $countones(enc_sym[3:0]) * 4 + $countones(enc_sym[7:4]), 10);
    chk(dtag, "dec_data", int'(dec_data), int'(m_data));
    chk(dtag, "dec_err", int'(dec_err), int'(m_err));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    in_valid = 1; rx_valid = 1; in_data = 5'd7; rx_sym = 8'h33;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "enc_valid", int'(enc_valid), 0);
    chk("R1", "enc_sym", int'(enc_sym), 0);
    chk("R1", "dec_valid", int'(dec_valid), 0);
    chk("R1", "dec_data", int'(dec_data), 0);
    chk("R1", "dec_err", int'(dec_err), 0);
    rst_n = 1;

    chk("R4", "digit table", int'({tab[0], tab[5]}), int'(8'h3C));
    for (int v = 0; v < 32; v++)
      step("R4", "R6", 1, 5'(v), 1, enc_of(v));

    for (int i = 0; i < 4; i++)
      step("R9", "R9", 0, 5'(i * 7 + 3), 0, 8'(i * 37 + 1));

    for (int h = 0; h < 6; h++)
      for (int l = 0; l < 6; l++)
        step("R2", (h * 6 + l >= 32) ? "R8" : "R6", 1, 5'(h * 5 + l), 1, {tab[h], tab[l]});

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        if ($countones(a[3:0]) != 2 || $countones(b[3:0]) != 2)
          step("R2", "R7", (a % 3) == 0, 5'(a + b), 1, {a[3:0], b[3:0]});

    step("R2", "R10", 1, 5'd0, 1, {4'b0011, 4'b0011 ^ 4'b0110});
    step("R2", "R10", 1, 5'd1, 1, {4'b1010 ^ 4'b1111, 4'b1100});

    for (int i = 0; i < 12; i++)
      step("R2", "R5", i % 2 == 0, 5'(31 - i), i % 3 != 0, enc_of(31 - i));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule